// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the serial front end of a sixteen-entry byte register bank, of the kind that holds a real-time clock's time and control values. A host reaches the bank through a four-wire SPI link in clock-phase-one operation. The slave works out the clock polarity from the idle level of SCLK when chip select falls. The first byte of each transfer is a command byte, which gives the direction and the register index. Data bytes follow, one at a time or as a burst, and the index advances by one after every byte. Chip select, SCLK and the input data are resynchronized and oversampled by a system clock that runs at least eight times faster than SCLK.

When chip select falls, a live time vector is copied into the low registers of the bank. Reads in that transfer then see one consistent, frozen time. Each completed write byte is committed to the bank and is also announced on a one-cycle strobe with its index and value, so that an external timekeeper can take new time values. The top register is the charger control register. Its fields are decoded into a charger enable, a diode selection and a resistor selection.

The controller has four states. IDLE waits with the output released. IDLE goes to CMD when a chip-select fall is seen. CMD assembles the command byte. When its eighth bit arrives, CMD goes to WRITE if bit 7 was 1 and to READ if it was 0. WRITE commits each received byte. READ streams bytes out. Every state other than IDLE returns to IDLE as soon as chip select is seen high.

Top module: `spi_regbank_slave`

## Requirements
- R1: The SCLK level sampled at the chip-select fall is the idle level. Input bits are sampled on the SCLK edge that returns to the idle level, and the output changes on the edge that leaves it. This gives both the idle-low and the idle-high mode.
- R2: Bytes are 8 bits, most significant bit first. The first byte after chip select falls is the command byte. Its bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 3:0 give the register index, and bits 6:4 are ignored. A write at 8n and a read at 0n therefore reach the same register n.
- R3: A written byte is committed only after its eighth bit. Each committed byte produces exactly one single-cycle wr_stb pulse, with wr_idx set to the register index and wr_data set to the byte.
- R4: In a burst write the index advances after each byte and wraps from 15 to 0 (command 8Fh continues at 80h).
- R5: In a burst read the index advances after each byte and wraps from 15 to 0 (0Fh continues at 00h).
- R6: Registers 0 to TIME_REGS-1 are loaded from time_live (register i from bits 8i+7:8i) when chip select falls. While chip select stays low they return the same values, even if time_live changes.
- R7: While chip select is high, SCLK and SDI have no effect: no strobe occurs, no register changes, and sdo_oe is 0 (sdo high impedance).
- R8: In a read, sdo_oe stays 0 for the whole command byte. It becomes 1 at the first leading edge of the first data byte and remains 1 until chip select rises.
- R9: If chip select rises before the eighth bit of a data byte, the partial byte is discarded: there is no strobe and the register is unchanged.
- R10: Register 15 holds charger control. chg_en is 1 only when bits 7:4 equal 1010b. chg_diode shows bits 3:2 and chg_res shows bits 1:0. The register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, high impedance when not driven |
| sdo_oe | output | 1 | 1 while sdo is driven |
| time_live | input | TIME_REGS*8 | Live time bytes, register i at bits 8i+7:8i |
| wr_stb | output | 1 | One-cycle pulse per committed write byte |
| wr_idx | output | 4 | Register index of the committed byte |
| wr_data | output | 8 | Value of the committed byte |
| chg_en | output | 1 | Charger enable |
| chg_diode | output | 2 | Diode selection field |
| chg_res | output | 2 | Resistor selection field |

## Verification
The bench builds the block with its defaults: TIME_REGS = 8 and SYNC_STAGES = 2. Eight time registers split the sixteen-entry index space evenly. A single read burst of twenty bytes therefore crosses from host-written registers into frozen time registers, through the wrap point, and back into the frozen ones. This shows the wrap and the freeze in the same transfer. Two synchronizer stages put the slave's response about four system cycles after each SCLK edge. That fits well within the bench's eight-cycle half period, so every mid-phase sample of sdo and sdo_oe shows a settled value in both polarities.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CMD   = 2'd1,
        S_WRITE = 2'd2,
        S_READ  = 2'd3
    } xfer_state_t;

    localparam int BYTE_W = 8;
    localparam int REG_NUM = 16;
    localparam logic [3:0] CHARGE_KEY = 4'b1010;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    if (STAGES <= 1) begin : g_single
        logic [WIDTH-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= RST_VAL;
            else        pipe_q <= d_in;
        end
        assign d_out = pipe_q;
    end else begin : g_multi
        logic [STAGES*WIDTH-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
            else        pipe_q <= {pipe_q[(STAGES-1)*WIDTH-1:0], d_in};
        end
        assign d_out = pipe_q[STAGES*WIDTH-1 -: WIDTH];
    end
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
    parameter int REG_NUM = 16,
    parameter int TIME_REGS = 8,
    parameter int DW = 8,
    localparam int IW = $clog2(REG_NUM)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snap,
    input  logic [TIME_REGS*DW-1:0] time_in,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic [IW-1:0]           rd_idx,
    output logic [DW-1:0]           rd_data,
    output logic [DW-1:0]           top_reg
);
    logic [REG_NUM*DW-1:0] flat_q;

    for (genvar g = 0; g < REG_NUM; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        if (g < TIME_REGS) begin : g_time
            // time cell: snapshot on chip-select fall wins over a write
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               cell_q <= '0;
                else if (snap)                            cell_q <= time_in[g*DW +: DW];
                else if (wr_en && wr_idx == IW'(g))       cell_q <= wr_data;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               cell_q <= '0;
                else if (wr_en && wr_idx == IW'(g))       cell_q <= wr_data;
            end
        end
        assign flat_q[g*DW +: DW] = cell_q;
    end

    assign rd_data = flat_q[int'(rd_idx)*DW +: DW];
    assign top_reg = flat_q[(REG_NUM-1)*DW +: DW];
endmodule

// File: rtl/spi_rb_charge.sv
module spi_rb_charge
    import spi_rb_pkg::*;
(
    input  logic [BYTE_W-1:0] ctrl,
    output logic              en,
    output logic [1:0]        diode,
    output logic [1:0]        res
);
    assign en    = (ctrl[7:4] == CHARGE_KEY);
    assign diode = ctrl[3:2];
    assign res   = ctrl[1:0];
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int TIME_REGS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        sclk,
    input  logic                        sdi,
    output logic                        sdo,
    output logic                        sdo_oe,
    input  logic [TIME_REGS*BYTE_W-1:0] time_live,
    output logic                        wr_stb,
    output logic [3:0]                  wr_idx,
    output logic [7:0]                  wr_data,
    output logic                        chg_en,
    output logic [1:0]                  chg_diode,
    output logic [1:0]                  chg_res
);
    localparam int IW = $clog2(REG_NUM);
    localparam int CW = $clog2(BYTE_W);

    // synchronized inputs: {cs_n, sclk, sdi}
    logic [2:0] sync_out;
    spi_rb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in({cs_n, sclk, sdi}), .d_out(sync_out)
    );
    logic cs_s, sclk_s, sdi_s;
    assign {cs_s, sclk_s, sdi_s} = sync_out;

    logic cs_d, sclk_d, cpol_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    logic cs_fall, sclk_edge, lead_edge, trail_edge;
    assign cs_fall    = cs_d & ~cs_s;
    assign sclk_edge  = sclk_s ^ sclk_d;
    assign lead_edge  = sclk_edge & (sclk_d == cpol_q);
    assign trail_edge = sclk_edge & (sclk_s == cpol_q);

    xfer_state_t state_q, state_d;
    logic [CW-1:0]     bit_q;
    logic [BYTE_W-1:0] rx_q, tx_q;
    logic [IW-1:0]     idx_q;
    logic              sdo_q, sdo_oe_q, wr_stb_q;
    logic [IW-1:0]     wr_idx_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic [BYTE_W-1:0] rd_data, ctrl_reg;
    logic              byte_end;
    logic [BYTE_W-1:0] rx_full;

    assign byte_end = trail_edge && (bit_q == CW'(BYTE_W-1));
    assign rx_full  = {rx_q[BYTE_W-2:0], sdi_s};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cs_fall) state_d = S_CMD;
            S_CMD: begin
                if (cs_s)          state_d = S_IDLE;
                else if (byte_end) state_d = rx_full[BYTE_W-1] ? S_WRITE : S_READ;
            end
            S_WRITE: if (cs_s) state_d = S_IDLE;
            S_READ:  if (cs_s) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q    <= 1'b0;
            bit_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            idx_q     <= '0;
            sdo_q     <= 1'b0;
            sdo_oe_q  <= 1'b0;
            wr_stb_q  <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            wr_stb_q <= 1'b0;
            if (cs_s) begin
                bit_q    <= '0;
                sdo_oe_q <= 1'b0;
            end else begin
                if (cs_fall) begin
                    cpol_q <= sclk_s;
                    bit_q  <= '0;
                end
                if (lead_edge && state_q == S_READ) begin
                    sdo_oe_q <= 1'b1;
                    if (bit_q == '0) begin
                        sdo_q <= rd_data[BYTE_W-1];
                        tx_q  <= {rd_data[BYTE_W-2:0], 1'b0};
                    end else begin
                        sdo_q <= tx_q[BYTE_W-1];
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                end
                if (trail_edge && state_q != S_IDLE) begin
                    rx_q  <= rx_full;
                    bit_q <= bit_q + 1'b1;
                    if (byte_end) begin
                        unique case (state_q)
                            S_CMD:   idx_q <= rx_full[IW-1:0];
                            S_WRITE: begin
                                wr_stb_q  <= 1'b1;
                                wr_idx_q  <= idx_q;
                                wr_data_q <= rx_full;
                                idx_q     <= idx_q + 1'b1;
                            end
                            S_READ:  idx_q <= idx_q + 1'b1;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    spi_rb_regfile #(.REG_NUM(REG_NUM), .TIME_REGS(TIME_REGS), .DW(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .snap(cs_fall), .time_in(time_live),
        .wr_en(wr_stb_q), .wr_idx(wr_idx_q), .wr_data(wr_data_q),
        .rd_idx(idx_q), .rd_data(rd_data), .top_reg(ctrl_reg)
    );

    spi_rb_charge u_charge (
        .ctrl(ctrl_reg), .en(chg_en), .diode(chg_diode), .res(chg_res)
    );

    assign sdo     = sdo_oe_q ? sdo_q : 1'bz;
    assign sdo_oe  = sdo_oe_q;
    assign wr_stb  = wr_stb_q;
    assign wr_idx  = wr_idx_q;
    assign wr_data = wr_data_q;

    // R7: chip select high releases the output
    a_r7_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_oe_q);

    // R8: output driven only inside a read transfer
    a_r8_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_q |-> state_q == S_READ);

    // R3: a strobe follows a write-phase cycle
    a_r3_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |-> $past(state_q) == S_WRITE);

    // R3: strobes are single-cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |=> !wr_stb_q);

    // R10: the charger only turns on through a write to the top register
    a_r10_enable_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_en) |-> $past(wr_stb_q) && $past(wr_idx_q) == IW'(REG_NUM-1));
endmodule

// File: tb/spi_regbank_slave_bench.sv
module spi_regbank_slave_bench;
    localparam int TIME_REGS = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [TIME_REGS*8-1:0] time_live = '0;
    logic wr_stb;
    logic [3:0] wr_idx;
    logic [7:0] wr_data;
    logic chg_en;
    logic [1:0] chg_diode, chg_res;

    always #2 clk = ~clk;

    spi_regbank_slave #(.TIME_REGS(TIME_REGS), .SYNC_STAGES(2)) u_spi_regbank_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .time_live(time_live),
        .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
        .chg_en(chg_en), .chg_diode(chg_diode), .chg_res(chg_res)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] tx_buf [0:31];
    logic [7:0] rx_buf [0:31];
    logic       oe_min [0:31];
    logic       oe_max [0:31];

    int stb_n = 0;
    logic [3:0] stb_i [0:63];
    logic [7:0] stb_d [0:63];

    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (stb_n < 64) begin
                stb_i[stb_n] = wr_idx;
                stb_d[stb_n] = wr_data;
            end
            stb_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [TIME_REGS*8-1:0] time_pattern(input logic [7:0] base);
        logic [TIME_REGS*8-1:0] v;
        for (int i = 0; i < TIME_REGS; i++) v[i*8 +: 8] = base + 8'(i);
        return v;
    endfunction

    // runs one transfer; the last byte is cut after last_bits bits
    task automatic spi_run(input logic cpol, input int nbytes, input int last_bits,
                           input bit swap_time, input logic [7:0] new_base);
        @(negedge clk);
        sclk = cpol;
        repeat (6) @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        if (swap_time) time_live = time_pattern(new_base);
        for (int b = 0; b < nbytes; b++) begin
            rx_buf[b] = 8'h00;
            oe_min[b] = 1'b1;
            oe_max[b] = 1'b0;
            for (int k = 7; k >= 0; k--) begin
                if (b == nbytes - 1 && (7 - k) >= last_bits) break;
                sclk = ~cpol;
                sdi  = tx_buf[b][k];
                repeat (HALF) @(negedge clk);
                rx_buf[b][k] = (sdo === 1'b1);
                if (sdo_oe) oe_max[b] = 1'b1; else oe_min[b] = 1'b0;
                sclk = cpol;
                repeat (HALF) @(negedge clk);
            end
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic write_one(input logic cpol, input logic [7:0] cmd, input logic [7:0] val);
        tx_buf[0] = cmd;
        tx_buf[1] = val;
        spi_run(cpol, 2, 8, 1'b0, 8'h00);
    endtask

    task automatic read_one(input logic cpol, input logic [7:0] cmd, output logic [7:0] val);
        tx_buf[0] = cmd;
        tx_buf[1] = 8'h00;
        spi_run(cpol, 2, 8, 1'b0, 8'h00);
        val = rx_buf[1];
    endtask

    task automatic t_reset;
        chk("R7 reset sdo_oe", 32'(sdo_oe), 0);
        chk("R10 reset chg_en", 32'(chg_en), 0);
        chk("R10 reset fields", {28'h0, chg_diode, chg_res}, 0);
        chk("R3 reset no strobe", stb_n, 0);
    endtask

    task automatic t_single(input logic cpol, input logic [3:0] n, input logic [7:0] val);
        int base;
        logic [7:0] got;
        base = stb_n;
        write_one(cpol, 8'h80 | 8'(n), val);
        chk("R3 one strobe", stb_n, base + 1);
        chk("R3 strobe index", 32'(stb_i[base]), 32'(n));
        chk("R3 strobe data", 32'(stb_d[base]), 32'(val));
        read_one(cpol, 8'(n), got);
        chk("R1 R2 readback", 32'(got), 32'(val));
        chk("R8 quiet during command", 32'(oe_max[0]), 0);
        chk("R8 driven during data", 32'(oe_min[1]), 1);
    endtask

    task automatic t_upper_bits;
        int base;
        logic [7:0] got;
        base = stb_n;
        write_one(1'b0, 8'hB9, 8'h6E);
        chk("R2 upper bits ignored idx", 32'(stb_i[base]), 9);
        read_one(1'b1, 8'h59, got);
        chk("R2 read alias", 32'(got), 32'h6E);
    endtask

    task automatic t_write_wrap;
        int base;
        base = stb_n;
        tx_buf[0] = 8'h8F;
        tx_buf[1] = 8'hA6;
        tx_buf[2] = 8'h12;
        tx_buf[3] = 8'h34;
        spi_run(1'b0, 4, 8, 1'b0, 8'h00);
        chk("R4 burst strobes", stb_n, base + 3);
        chk("R4 first idx", 32'(stb_i[base]), 15);
        chk("R4 wrap idx", 32'(stb_i[base+1]), 0);
        chk("R4 after wrap idx", 32'(stb_i[base+2]), 1);
        chk("R4 after wrap data", 32'(stb_d[base+2]), 32'h34);
        chk("R10 enable on key", 32'(chg_en), 1);
        chk("R10 diode field", 32'(chg_diode), 1);
        chk("R10 resistor field", 32'(chg_res), 2);
        write_one(1'b1, 8'h8F, 8'h96);
        chk("R10 no enable off key", 32'(chg_en), 0);
        chk("R10 fields off key", {28'h0, chg_diode, chg_res}, 32'h6);
    endtask

    task automatic t_read_wrap_freeze;
        logic [7:0] got;
        write_one(1'b0, 8'h8E, 8'h77);
        time_live = time_pattern(8'h20);
        tx_buf[0] = 8'h0E;
        for (int i = 1; i <= 20; i++) tx_buf[i] = 8'h00;
        spi_run(1'b0, 21, 8, 1'b1, 8'h50);
        chk("R5 reg14", 32'(rx_buf[1]), 32'h77);
        chk("R5 reg15", 32'(rx_buf[2]), 32'h96);
        chk("R5 wrap to reg0", 32'(rx_buf[3]), 32'h20);
        chk("R6 shadow reg7", 32'(rx_buf[10]), 32'h27);
        chk("R5 second pass reg14", 32'(rx_buf[17]), 32'h77);
        chk("R6 frozen reg0", 32'(rx_buf[19]), 32'h20);
        chk("R6 frozen reg1", 32'(rx_buf[20]), 32'h21);
        chk("R8 driven through burst", 32'(oe_min[20]), 1);
        read_one(1'b1, 8'h03, got);
        chk("R6 new snapshot", 32'(got), 32'h53);
    endtask

    task automatic t_partial;
        int base;
        logic [7:0] got;
        write_one(1'b0, 8'h8C, 8'h3C);
        base = stb_n;
        tx_buf[0] = 8'h8C;
        tx_buf[1] = 8'hFF;
        spi_run(1'b0, 2, 5, 1'b0, 8'h00);
        chk("R9 no strobe on cut byte", stb_n, base);
        read_one(1'b0, 8'h0C, got);
        chk("R9 register kept", 32'(got), 32'h3C);
    endtask

    task automatic t_deselected;
        int base;
        logic oe_seen;
        logic [7:0] got;
        base = stb_n;
        oe_seen = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            sclk = ~sclk;
            sdi  = i[1];
            repeat (HALF) @(negedge clk);
            if (sdo_oe) oe_seen = 1'b1;
        end
        chk("R7 no strobe while deselected", stb_n, base);
        chk("R7 output released", 32'(oe_seen), 0);
        read_one(1'b1, 8'h0C, got);
        chk("R7 register untouched", 32'(got), 32'h3C);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single(1'b0, 4'hB, 8'h5A);
        t_single(1'b1, 4'hD, 8'hC3);
        t_upper_bits();
        t_write_wrap();
        t_read_wrap_freeze();
        t_partial();
        t_deselected();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule